// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a small bank of control registers on a simple synchronous bus with an address, write data, a write strobe and combinational read data. It holds two multi-function pin control words, a hardware strap word and a write-protection key. Every register except the key is protected. A write to a protected register only takes effect while the bank is unlocked, and the bank unlocks only when the exact 32-bit magic value is written to the key offset.

The strap word is captured from a set of input pins while reset is held. Software can change it afterwards through two addresses. A one written at the set address forces the matching strap bit high. A one written at the clear address forces the matching bit low. A zero has no effect at either address. Reading the clear address does not return the strap word; it returns a fixed revision identifier. The pin control words and the strap word drive outputs of the block at all times.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the bank becomes locked, both pin control outputs become 0, and `strap_q` takes the value of `strap_pins`.
- R2: Writing 32'h1688A8A8 to offset 0x00 unlocks the bank from the next clock edge. Reading offset 0x00 then returns 32'h1.
- R3: Writing any other value to offset 0x00, 32'h000000AA for example, locks the bank from the next clock edge. Reading offset 0x00 then returns 32'h0.
- R4: While the bank is locked, writes to offsets 0x70, 0x7C, 0x80 and 0x8C change neither the outputs nor any value read back.
- R5: While unlocked, a write to offset 0x80 loads `pinctl_a` and a write to offset 0x8C loads `pinctl_b` at the next clock edge. Reading either offset returns the stored word.
- R6: While unlocked, a write to offset 0x70 sets every strap bit whose write-data bit is 1 and leaves the other bits unchanged. Reading 0x70 returns the strap word.
- R7: While unlocked, a write to offset 0x7C clears every strap bit whose write-data bit is 1 and leaves the other bits unchanged.
- R8: A read of offset 0x7C returns the constant revision identifier (default 32'h0304_0A11). Reads are combinational, so `bus_rdata` is valid in the same cycle as `bus_addr`.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and does not change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| strap_pins | input | 32 | Strap values captured during reset |
| pinctl_a | output | 32 | Pin control word at offset 0x80 |
| pinctl_b | output | 32 | Pin control word at offset 0x8C |
| strap_q | output | 32 | Current strap word |

## Verification
A write strobe sampled at one clock edge shows its effect on the outputs and on the lock state right after that edge. The bench therefore drives each write on a falling edge, drops the strobe on the next falling edge, and checks all three outputs and the lock readback at that point. Reads have no latency. For a read, the bench sets the address on a falling edge and samples `bus_rdata` one nanosecond later, inside the same cycle. Expected values come from a bench-side model that is updated once per write.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
// Shared types for the key-protected control bank.
// Assumes one access per cycle; the decode result selects exactly one target.
package sysctl_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KEY,
        SEL_STRAP_SET,
        SEL_STRAP_CLR,
        SEL_PIN_A,
        SEL_PIN_B
    } reg_sel_e;
endpackage

// File: rtl/sysctl_key_lock.sv
`timescale 1ns/1ps
// Holds the lock state of the bank.
// Any write to the key offset updates it: the magic value unlocks, every other
// value locks. Assumes key_wr is already qualified by the address decode.
module sysctl_key_lock #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h1688A8A8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY);

    // Track the lock state from writes to the key offset.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (key_wr) unlocked <= (wdata == KEY_W);
    end

    p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata == KEY_W) |=> unlocked);
    p_other_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata != KEY_W) |=> !unlocked);
    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(unlocked));
endmodule

// File: rtl/sysctl_strap_reg.sv
`timescale 1ns/1ps
// Strap word: captured from pins during reset, then changed only through the
// set (W1S) and clear (W1C) requests. Assumes set_req and clr_req are
// never both high, which the single-address decode guarantees.
module sysctl_strap_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              set_req,
    input  logic              clr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] q
);
    logic set_en;
    logic clr_en;

    // Gate requests with the lock state.
    always_comb begin
        set_en = set_req && unlocked;
        clr_en = clr_req && unlocked;
    end

    // Load from the pins in reset; apply W1S and W1C afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= pins;
        else if (set_en) q <= q | wdata;
        else if (clr_en) q <= q & ~wdata;
    end

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(q));
    p_set_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && set_req) |=> ((q & $past(wdata)) == $past(wdata)));
    p_clr_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && clr_req) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/sysctl_pin_reg.sv
`timescale 1ns/1ps
// One read/write pin control word, cleared in reset. It loads only when
// the decode selects it and the bank is unlocked.
module sysctl_pin_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Store write data when the write is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= '0;
        else if (wr_req && unlocked) q <= wdata;
    end

    p_pin_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && unlocked) |=> (q == $past(wdata)));
    p_pin_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(q));
endmodule

// File: rtl/sysctl_keyed_regs.sv
`timescale 1ns/1ps
// Top of the key-protected control bank: address decode, lock state,
// strap word, two pin control words and the combinational read mux.
// Assumes word-aligned byte offsets and one access per cycle.
module sysctl_keyed_regs
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [31:0]       UNLOCK    = 32'h1688A8A8,
    parameter logic [31:0]       REV_ID    = 32'h0304_0A11,
    parameter logic [ADDR_W-1:0] OFF_KEY   = 8'h00,
    parameter logic [ADDR_W-1:0] OFF_SET   = 8'h70,
    parameter logic [ADDR_W-1:0] OFF_CLR   = 8'h7C,
    parameter logic [ADDR_W-1:0] OFF_PIN_A = 8'h80,
    parameter logic [ADDR_W-1:0] OFF_PIN_B = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] strap_pins,
    output logic [DATA_W-1:0] pinctl_a,
    output logic [DATA_W-1:0] pinctl_b,
    output logic [DATA_W-1:0] strap_q
);
    localparam int N_PIN = 2;

    reg_sel_e                      sel;
    logic                          unlocked;
    logic [N_PIN-1:0][DATA_W-1:0]  pin_q;
    logic [N_PIN-1:0]              pin_wr;

    // Decode the byte offset into a register select.
    always_comb begin
        if      (bus_addr == OFF_KEY)   sel = SEL_KEY;
        else if (bus_addr == OFF_SET)   sel = SEL_STRAP_SET;
        else if (bus_addr == OFF_CLR)   sel = SEL_STRAP_CLR;
        else if (bus_addr == OFF_PIN_A) sel = SEL_PIN_A;
        else if (bus_addr == OFF_PIN_B) sel = SEL_PIN_B;
        else                            sel = SEL_NONE;
    end

    sysctl_key_lock #(.DATA_W(DATA_W), .KEY(UNLOCK)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (bus_wr && sel == SEL_KEY),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    sysctl_strap_reg #(.DATA_W(DATA_W)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlocked (unlocked),
        .set_req  (bus_wr && sel == SEL_STRAP_SET),
        .clr_req  (bus_wr && sel == SEL_STRAP_CLR),
        .wdata    (bus_wdata),
        .pins     (strap_pins),
        .q        (strap_q)
    );

    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_PIN_A : SEL_PIN_B;
        // Raise this word's write request on a matching write.
        always_comb pin_wr[g] = bus_wr && (sel == MY_SEL);

        sysctl_pin_reg #(.DATA_W(DATA_W)) u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .unlocked (unlocked),
            .wr_req   (pin_wr[g]),
            .wdata    (bus_wdata),
            .q        (pin_q[g])
        );
    end

    assign pinctl_a = pin_q[0];
    assign pinctl_b = pin_q[1];

    // Return the selected register; unmapped offsets read as zero.
    always_comb begin
        unique case (sel)
            SEL_KEY:       bus_rdata = {{(DATA_W-1){1'b0}}, unlocked};
            SEL_STRAP_SET: bus_rdata = strap_q;
            SEL_STRAP_CLR: bus_rdata = DATA_W'(REV_ID);
            SEL_PIN_A:     bus_rdata = pin_q[0];
            SEL_PIN_B:     bus_rdata = pin_q[1];
            default:       bus_rdata = '0;
        endcase
    end

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0));
    p_revid_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STRAP_CLR) |-> (bus_rdata == DATA_W'(REV_ID)));
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pinctl_a == '0 && pinctl_b == '0 && !unlocked));
endmodule

// File: tb/test_sysctl_keyed_regs.sv
`timescale 1ns/1ps
module test_sysctl_keyed_regs;
    localparam logic [31:0] KEY = 32'h1688A8A8;
    localparam logic [31:0] RID = 32'h0304_0A11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] strap_pins = 32'hA5A5_0F0F;
    logic [31:0] pinctl_a, pinctl_b, strap_q;

    int n_chk = 0;
    int n_fail = 0;

    logic        m_lock;
    logic [31:0] m_strap, m_a, m_b;

    always #2.5 clk = ~clk;

    sysctl_keyed_regs i_sysctl_keyed_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .strap_pins(strap_pins),
        .pinctl_a(pinctl_a), .pinctl_b(pinctl_b), .strap_q(strap_q)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h00:   return {31'b0, m_lock};
            8'h70:   return m_strap;
            8'h7C:   return RID;
            8'h80:   return m_a;
            8'h8C:   return m_b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h00:        return "R2";
            8'h70:        return "R6";
            8'h7C:        return "R8";
            8'h80, 8'h8C: return "R5";
            default:      return "R9";
        endcase
    endfunction

    task automatic do_reset(logic [31:0] pins);
        @(negedge clk);
        strap_pins = pins;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lock = 1'b0; m_strap = pins; m_a = '0; m_b = '0;
        chk("R1", pinctl_a, 32'h0);
        chk("R1", pinctl_b, 32'h0);
        chk("R1", strap_q, pins);
    endtask

    task automatic rd(logic [7:0] a, string req);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h00) m_lock = (d == KEY);
        else if (m_lock) begin
            case (a)
                8'h70: m_strap = m_strap | d;
                8'h7C: m_strap = m_strap & ~d;
                8'h80: m_a = d;
                8'h8C: m_b = d;
                default: ;
            endcase
        end
        chk(req, pinctl_a, m_a);
        chk(req, pinctl_b, m_b);
        chk(req, strap_q, m_strap);
        bus_addr = 8'h00;
        #1;
        chk(req, bus_rdata, {31'b0, m_lock});
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [7:0] addrs [5];
        seed = 32'd7;
        void'($urandom(seed));
        addrs[0] = 8'h00; addrs[1] = 8'h70; addrs[2] = 8'h7C;
        addrs[3] = 8'h80; addrs[4] = 8'h8C;

        // R1 reset state and lock readback
        do_reset(32'hA5A5_0F0F);
        rd(8'h00, "R1");
        // R4 writes while locked are ignored
        wr(8'h80, 32'hFFFF_FFFF, "R4");
        wr(8'h8C, 32'h1234_5678, "R4");
        wr(8'h70, 32'hFFFF_FFFF, "R4");
        wr(8'h7C, 32'hFFFF_FFFF, "R4");
        // R2 unlock, R5 read/write
        wr(8'h00, KEY, "R2");
        rd(8'h00, "R2");
        wr(8'h80, 32'hDEAD_BEEF, "R5");
        wr(8'h8C, 32'h0BAD_F00D, "R5");
        rd(8'h80, "R5");
        rd(8'h8C, "R5");
        // R6 set and R7 clear, zero bits have no effect
        wr(8'h70, 32'h0000_0000, "R6");
        wr(8'h70, 32'h5000_00F0, "R6");
        wr(8'h7C, 32'h0000_0000, "R7");
        wr(8'h7C, 32'h0005_000F, "R7");
        rd(8'h70, "R6");
        // R8 revision constant, not the strap word
        rd(8'h7C, "R8");
        // R9 unmapped accesses
        wr(8'h44, 32'hFFFF_FFFF, "R9");
        rd(8'h44, "R9");
        rd(8'hFC, "R9");
        // R3 relock with a near-miss key and with 0xAA
        wr(8'h00, KEY ^ 32'h1, "R3");
        wr(8'h00, KEY, "R2");
        wr(8'h00, 32'h0000_00AA, "R3");
        wr(8'h80, 32'h1111_1111, "R4");

        // Random mix of writes and reads
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [7:0] a;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            d = $urandom();
            if (op < 5) a = addrs[op];
            else if (op == 5) a = {$urandom_range(0, 63), 2'b00};
            else a = addrs[$urandom_range(0, 4)];
            if (op == 0 && $urandom_range(0, 1) == 1) d = KEY;
            if (op == 9) rd(a, tag_of(a));
            else wr(a, d, m_lock ? tag_of(a) : "R4");
        end

        // R1 second reset with different pins clears unlock
        wr(8'h00, KEY, "R2");
        do_reset(32'h0123_4567);
        rd(8'h00, "R1");
        rd(8'h70, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule